// File: doc/BRIEF.md
# Bitplane Pixel Plot Cache

This block takes single-pixel plot requests, each made of an 8-bit column, an 8-bit row and an 8-bit colour. It gathers them into an 8-pixel row buffer and writes finished rows to planar, tile-organised memory through a byte-wide request/acknowledge port. The store is split into separate bitplanes. A second row buffer sits behind the first. A row is written to memory only when it is pushed out of this second buffer, so most plots cost no memory cycles at all.

Before it is buffered, each plot passes through a colour stage. This stage can drop pixels whose colour counts as transparent, and it can pick one nibble of the colour by the parity of the coordinates to give a dither pattern. The tile address generator covers three screen heights and an object layout. A read-pixel request first writes both buffers back to memory. It then collects one bit per plane for the pixel that was asked for. Each accepted plot also returns the column plus one, so the caller can step along a row without keeping its own count.

Top module: `plane_plot_cache`

## Requirements
- R1: While reset is high and on the cycle after it, `busy`, `mem_req` and `rd_done` are 0 and `next_x` is 0.
- R2: A plot is accepted when `plot_valid` is high and `busy` is low. On the next cycle `next_x` equals the plot column plus 1 (modulo 256). This happens even when the pixel is dropped. A read request made in the same cycle as an accepted plot is ignored and never produces `rd_done`.
- R3: Pixels that share the same column group (column with its low 3 bits cleared) and the same row go into the front buffer without any memory traffic. A pixel at column x goes to slot (x AND 7) XOR 7.
- R4: A plot to a different group or row first writes back the rear buffer, if any of its slots are valid. The front buffer then moves to the rear and is re-tagged with the new position. When all 8 front slots become valid, the same move happens at once, with no memory traffic if the rear buffer is empty.
- R5: The plane count comes from `cfg_depth`: 4 or 8 select that many planes, and any other value selects 2. Plane p lives at byte offset 16·(p>>1) + (p AND 1) inside the pixel's row of the tile. Bit s of that byte holds bit p of the pixel in slot s.
- R6: A rear buffer with all 8 slots valid is written with one write per plane and no reads. A partly valid one does a read then a write per plane, and the written byte keeps the memory bits of the slots that are not valid.
- R7: The byte address is 0x700000 + `cfg_base`·1024 + tile·(planes·8) + (row AND 7)·2 + plane offset. With g = column AND 0xF8 and r = row>>3, the tile is 2g + r for height code 0 or 3, 2g + g/2 + r for code 1, and 3g + r for code 2.
- R8: When `cfg_obj` is 1, the tile is (row bit 7)·512 + (column bit 7)·256 + (row bits 6..3)·16 + (column bits 6..3), whatever the height code.
- R9: If `cfg_draw_zero` is 0, a pixel is dropped when its test colour has zero in its low 2 bits (2 planes), its low 4 bits (4 planes) or all 8 bits (8 planes). The test colour is the colour's low nibble when `cfg_low_nibble` is 1, and the full colour otherwise.
- R10: With `cfg_dither` set and fewer than 8 planes, the stored value is the colour's high nibble when bit 0 of (column XOR row) is 1, and its low nibble otherwise.
- R11: A read-pixel request writes back the rear buffer, then the front buffer, and then reads each plane. It pulses `rd_done` for one cycle, with bit p of `rd_data` equal to bit (x AND 7) XOR 7 of plane p's byte. Bits at or above the plane count are 0.
- R12: `busy` is high whenever memory traffic is in progress, and plots are not accepted while it is high. A request holds its address, direction and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plot_valid | input | 1 | Plot request |
| plot_x | input | 8 | Plot column |
| plot_y | input | 8 | Plot row |
| plot_color | input | 8 | Plot colour |
| rd_valid | input | 1 | Read-pixel request |
| rd_x | input | 8 | Read column |
| rd_y | input | 8 | Read row |
| cfg_depth | input | 4 | Planes per pixel (2, 4, 8) |
| cfg_height | input | 2 | Screen height code |
| cfg_obj | input | 1 | Object tile layout |
| cfg_base | input | BASE_W | Screen base, in units of 1 KiB |
| cfg_draw_zero | input | 1 | Draw transparent colours too |
| cfg_low_nibble | input | 1 | Transparency test on the low nibble only |
| cfg_dither | input | 1 | Dither nibble select |
| busy | output | 1 | Write-back or read in progress |
| next_x | output | 8 | Last accepted column plus one |
| rd_done | output | 1 | Read-pixel result valid |
| rd_data | output | 8 | Read-pixel colour |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory acknowledge, read data valid |

## Verification
The two functions that can fall in the same cycle are a plot and a read-pixel request. To provoke this, the bench raises both requests on one idle cycle. It then judges the outcome: `next_x` must show the plot column plus one, the plotted pixel must appear in memory once a later read flushes the buffers, and no `rd_done` may arrive during a long wait afterwards. A second kind of overlap is a plot held on `plot_valid` while a write-back is under way. The bench checks that `next_x` does not move and that the held pixel never reaches memory.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int PIX_W    = 8;
    localparam int LINE_PIX = 8;
    localparam int COORD_W  = 8;
    localparam int GRP_W    = COORD_W - 3;
    localparam int PLANE_W  = 3;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic [GRP_W-1:0]                xg;
        logic [COORD_W-1:0]              y;
        logic [LINE_PIX-1:0]             valid;
        logic [LINE_PIX-1:0][PIX_W-1:0]  pix;
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WB_START, ST_WB_RD, ST_WB_WR, ST_WB_END, ST_PIX_RD, ST_PIX_DONE
    } state_t;

    // Plane count: 4 or 8 pass through, anything else means 2
    function automatic logic [3:0] depth_of(input logic [3:0] code);
        return (code == 4'd4 || code == 4'd8) ? code : 4'd2;
    endfunction

    // Byte offset of a plane inside one tile row
    function automatic logic [5:0] plane_offset(input logic [PLANE_W-1:0] p);
        return {p[2:1], 3'b000, p[0]};
    endfunction

    // Gather bit p of every slot into one plane byte
    function automatic logic [LINE_PIX-1:0] plane_byte(input line_t ln, input logic [PLANE_W-1:0] p);
        logic [LINE_PIX-1:0] b;
        for (int s = 0; s < LINE_PIX; s++) b[s] = ln.pix[s][p];
        return b;
    endfunction
endpackage

// File: rtl/ppc_tile_addr.sv
module ppc_tile_addr
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 8,
    parameter logic [ADDR_W-1:0] REGION = 24'h70_0000
) (
    input  logic [GRP_W-1:0]   grp_x,
    input  logic [COORD_W-1:0] row_y,
    input  logic [PLANE_W-1:0] plane,
    input  logic [3:0]         depth,
    input  logic [1:0]         height,
    input  logic               obj_mode,
    input  logic [BASE_W-1:0]  base,
    output logic [ADDR_W-1:0]  addr
);
    localparam int IDX_W = 10;

    logic [IDX_W-1:0] xg, yg, idx;

    always_comb begin
        xg = IDX_W'({grp_x, 3'b000});
        yg = IDX_W'(row_y[7:3]);
        if (obj_mode) begin
            idx = IDX_W'({row_y[7], 9'b0}) + IDX_W'({grp_x[4], 8'b0})
                + IDX_W'({row_y[6:3], 4'b0}) + IDX_W'(grp_x[3:0]);
        end else begin
            case (height)
                2'd1:    idx = (xg << 1) + (xg >> 1) + yg;
                2'd2:    idx = (xg << 1) + xg + yg;
                default: idx = (xg << 1) + yg;
            endcase
        end
        addr = REGION + (ADDR_W'(base) << 10)
             + ADDR_W'(idx) * ADDR_W'({depth, 3'b000})
             + ADDR_W'({row_y[2:0], 1'b0})
             + ADDR_W'(plane_offset(plane));
    end
endmodule

// File: rtl/ppc_pixel_prep.sv
module ppc_pixel_prep
    import ppc_pkg::*;
(
    input  pix_t       color,
    input  logic [3:0] depth,
    input  logic       odd_cell,
    input  logic       draw_zero,
    input  logic       low_nibble,
    input  logic       dither_en,
    output logic       skip,
    output pix_t       value
);
    pix_t probe;
    logic clear;

    always_comb begin
        probe = low_nibble ? (color & 8'h0F) : color;
        case (depth)
            4'd8:    clear = (probe == 8'h00);
            4'd4:    clear = (probe[3:0] == 4'h0);
            default: clear = (probe[1:0] == 2'b00);
        endcase
        skip  = !draw_zero && clear;
        value = color;
        if (dither_en && depth != 4'd8)
            value = {4'b0000, odd_cell ? color[7:4] : color[3:0]};
    end
endmodule

// File: rtl/plane_plot_cache.sv
module plane_plot_cache
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              plot_valid,
    input  logic [7:0]        plot_x,
    input  logic [7:0]        plot_y,
    input  logic [7:0]        plot_color,
    input  logic              rd_valid,
    input  logic [7:0]        rd_x,
    input  logic [7:0]        rd_y,
    input  logic [3:0]        cfg_depth,
    input  logic [1:0]        cfg_height,
    input  logic              cfg_obj,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              cfg_draw_zero,
    input  logic              cfg_low_nibble,
    input  logic              cfg_dither,
    output logic              busy,
    output logic [7:0]        next_x,
    output logic              rd_done,
    output logic [7:0]        rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);
    localparam logic [LINE_PIX-1:0] ALL_VALID = '1;

    state_t               st;
    line_t                prim, sec, wb_line;
    logic                 wb_pri, op_read, pend_ins;
    logic [COORD_W-1:0]   rq_x, rq_y;
    pix_t                 rq_val;
    logic [PLANE_W-1:0]   plane;
    logic [LINE_PIX-1:0]  merge_q, plane_bits, new_valid;
    logic [7:0]           acc;
    logic [3:0]           depth;
    logic                 plot_go, rd_go, tag_hit, wb_full, last_plane, skip;
    logic [2:0]           slot, rq_slot;
    pix_t                 value;
    logic [GRP_W-1:0]     a_xg;
    logic [COORD_W-1:0]   a_y;

    assign depth      = depth_of(cfg_depth);
    assign plot_go    = plot_valid && st == ST_IDLE;
    assign rd_go      = rd_valid && !plot_valid && st == ST_IDLE;
    assign slot       = plot_x[2:0] ^ 3'd7;
    assign rq_slot    = rq_x[2:0] ^ 3'd7;
    assign tag_hit    = prim.xg == plot_x[7:3] && prim.y == plot_y;
    assign new_valid  = prim.valid | (LINE_PIX'(1) << slot);
    assign wb_line    = wb_pri ? prim : sec;
    assign wb_full    = wb_line.valid == ALL_VALID;
    assign plane_bits = plane_byte(wb_line, plane);
    assign last_plane = ({1'b0, plane} + 4'd1) == depth;
    assign a_xg       = (st == ST_PIX_RD) ? rq_x[7:3] : wb_line.xg;
    assign a_y        = (st == ST_PIX_RD) ? rq_y : wb_line.y;

    ppc_pixel_prep u_prep (
        .color      (plot_color),
        .depth      (depth),
        .odd_cell   (plot_x[0] ^ plot_y[0]),
        .draw_zero  (cfg_draw_zero),
        .low_nibble (cfg_low_nibble),
        .dither_en  (cfg_dither),
        .skip       (skip),
        .value      (value)
    );

    ppc_tile_addr #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_addr (
        .grp_x    (a_xg),
        .row_y    (a_y),
        .plane    (plane),
        .depth    (depth),
        .height   (cfg_height),
        .obj_mode (cfg_obj),
        .base     (cfg_base),
        .addr     (mem_addr)
    );

    assign busy      = st != ST_IDLE;
    assign mem_req   = st == ST_WB_RD || st == ST_WB_WR || st == ST_PIX_RD;
    assign mem_we    = st == ST_WB_WR;
    assign mem_wdata = wb_full ? plane_bits : merge_q;
    assign rd_done   = st == ST_PIX_DONE;
    assign rd_data   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            prim     <= '0;
            sec      <= '0;
            wb_pri   <= 1'b0;
            op_read  <= 1'b0;
            pend_ins <= 1'b0;
            rq_x     <= '0;
            rq_y     <= '0;
            rq_val   <= '0;
            plane    <= '0;
            merge_q  <= '0;
            acc      <= '0;
            next_x   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (plot_go) begin
                        next_x <= plot_x + 8'd1;
                        if (!skip) begin
                            wb_pri  <= 1'b0;
                            op_read <= 1'b0;
                            if (tag_hit) begin
                                prim.pix[slot]   <= value;
                                prim.valid[slot] <= 1'b1;
                                if (new_valid == ALL_VALID) begin
                                    pend_ins <= 1'b0;
                                    st       <= ST_WB_START;
                                end
                            end else begin
                                rq_x     <= plot_x;
                                rq_y     <= plot_y;
                                rq_val   <= value;
                                pend_ins <= 1'b1;
                                st       <= ST_WB_START;
                            end
                        end
                    end else if (rd_go) begin
                        rq_x    <= rd_x;
                        rq_y    <= rd_y;
                        op_read <= 1'b1;
                        wb_pri  <= 1'b0;
                        st      <= ST_WB_START;
                    end
                end
                ST_WB_START: begin
                    plane <= '0;
                    if (wb_line.valid == '0) st <= ST_WB_END;
                    else                     st <= wb_full ? ST_WB_WR : ST_WB_RD;
                end
                ST_WB_RD: begin
                    if (mem_ack) begin
                        merge_q <= (plane_bits & wb_line.valid) | (mem_rdata & ~wb_line.valid);
                        st      <= ST_WB_WR;
                    end
                end
                ST_WB_WR: begin
                    if (mem_ack) begin
                        if (last_plane) st <= ST_WB_END;
                        else begin
                            plane <= plane + 3'd1;
                            st    <= wb_full ? ST_WB_WR : ST_WB_RD;
                        end
                    end
                end
                ST_WB_END: begin
                    if (!op_read) begin
                        sec        <= prim;
                        prim.valid <= '0;
                        if (pend_ins) begin
                            prim.xg           <= rq_x[7:3];
                            prim.y            <= rq_y;
                            prim.valid        <= LINE_PIX'(1) << rq_slot;
                            prim.pix[rq_slot] <= rq_val;
                        end
                        st <= ST_IDLE;
                    end else if (!wb_pri) begin
                        sec.valid <= '0;
                        wb_pri    <= 1'b1;
                        st        <= ST_WB_START;
                    end else begin
                        prim.valid <= '0;
                        plane      <= '0;
                        acc        <= '0;
                        st         <= ST_PIX_RD;
                    end
                end
                ST_PIX_RD: begin
                    if (mem_ack) begin
                        acc[plane] <= mem_rdata[rq_slot];
                        if (last_plane) st <= ST_PIX_DONE;
                        else            plane <= plane + 3'd1;
                    end
                end
                ST_PIX_DONE: st <= ST_IDLE;
                default:     st <= ST_IDLE;
            endcase
        end
    end

    // R12: request fields hold until acknowledged
    p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R12: no memory traffic while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
    // R12: a stalled plot leaves the column echo untouched
    p_stall_r12: assert property (@(posedge clk) disable iff (rst)
        busy && plot_valid |=> $stable(next_x));
    // R2: accepted plot echoes column plus one
    p_next_x_r2: assert property (@(posedge clk) disable iff (rst)
        plot_valid && !busy |=> next_x == $past(plot_x) + 8'd1);
    // R4: a full front buffer never survives into idle
    p_full_moves_r4: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> prim.valid != ALL_VALID);
    // R6: writes only come from a buffer holding valid pixels
    p_write_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> wb_line.valid != '0);
    // R11: result is given only after both buffers are written back
    p_rd_after_flush_r11: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> sec.valid == '0 && prim.valid == '0);
endmodule

// File: tb/test_plane_plot_cache.sv
`timescale 1ns/1ps
module test_plane_plot_cache;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic plot_valid = 0, rd_valid = 0;
    logic [7:0] plot_x = 0, plot_y = 0, plot_color = 0, rd_x = 0, rd_y = 0;
    logic [3:0] cfg_depth = 4;
    logic [1:0] cfg_height = 0;
    logic cfg_obj = 0, cfg_draw_zero = 1, cfg_low_nibble = 0, cfg_dither = 0;
    logic [7:0] cfg_base = 0;
    logic busy, rd_done, mem_req, mem_we;
    logic [7:0] next_x, rd_data, mem_wdata;
    logic [7:0] mem_rdata = 0;
    logic mem_ack = 0;
    logic [23:0] mem_addr;

    plane_plot_cache i_plane_plot_cache (
        .clk(clk), .rst(rst), .plot_valid(plot_valid), .plot_x(plot_x), .plot_y(plot_y),
        .plot_color(plot_color), .rd_valid(rd_valid), .rd_x(rd_x), .rd_y(rd_y),
        .cfg_depth(cfg_depth), .cfg_height(cfg_height), .cfg_obj(cfg_obj), .cfg_base(cfg_base),
        .cfg_draw_zero(cfg_draw_zero), .cfg_low_nibble(cfg_low_nibble), .cfg_dither(cfg_dither),
        .busy(busy), .next_x(next_x), .rd_done(rd_done), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_vec = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0, gap = 0;
    bit slow = 0, finished = 0;
    logic [7:0] dmem [int];
    logic [7:0] rmem [int];

    function automatic logic [7:0] pat(int a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] dget(int a);
        return dmem.exists(a) ? dmem[a] : pat(a);
    endfunction
    function automatic logic [7:0] rget(int a);
        return rmem.exists(a) ? rmem[a] : pat(a);
    endfunction

    // memory model: variable latency, ack with read data
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            gap = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (gap != 0) gap = gap - 1;
            else begin
                if (mem_we) begin
                    dmem[int'(mem_addr)] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= dget(int'(mem_addr));
                    rd_cnt++;
                end
                mem_ack <= 1'b1;
                slow = !slow;
                gap = slow ? 2 : 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int depth_eff();
        return (cfg_depth == 4 || cfg_depth == 8) ? int'(cfg_depth) : 2;
    endfunction

    function automatic int ref_addr(int x, int y, int p);
        int idx, xg, d;
        d = depth_eff();
        xg = x & 'hF8;
        if (cfg_obj) idx = ((y & 'h80) << 2) + ((x & 'h80) << 1) + ((y & 'h78) << 1) + ((x & 'h78) >> 3);
        else if (cfg_height == 1) idx = (xg << 1) + (xg >> 1) + ((y & 'hF8) >> 3);
        else if (cfg_height == 2) idx = (xg << 1) + xg + ((y & 'hF8) >> 3);
        else idx = (xg << 1) + ((y & 'hF8) >> 3);
        return 'h700000 + (int'(cfg_base) << 10) + idx * d * 8 + (y & 7) * 2 + ((p >> 1) << 4) + (p & 1);
    endfunction

    task automatic ref_plot(int x, int y, int c);
        int d, ck, v, s, a;
        bit clr;
        logic [7:0] b;
        d = depth_eff();
        ck = cfg_low_nibble ? (c & 15) : c;
        clr = (d == 2) ? ((ck & 3) == 0) : (d == 4) ? ((ck & 15) == 0) : (ck == 0);
        if (!cfg_draw_zero && clr) return;
        v = c;
        if (cfg_dither && d != 8) begin
            if (((x ^ y) & 1) != 0) v = v >> 4;
            v = v & 15;
        end
        s = (x & 7) ^ 7;
        for (int p = 0; p < d; p++) begin
            a = ref_addr(x, y, p);
            b = rget(a);
            b[s] = v[p];
            rmem[a] = b;
        end
    endtask

    function automatic logic [7:0] ref_pixel(int x, int y);
        logic [7:0] r, b;
        r = 0;
        for (int p = 0; p < depth_eff(); p++) begin
            b = rget(ref_addr(x, y, p));
            r[p] = b[(x & 7) ^ 7];
        end
        return r;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_plot(int x, int y, int c);
        wait_idle();
        plot_x = 8'(x); plot_y = 8'(y); plot_color = 8'(c); plot_valid = 1;
        @(negedge clk);
        plot_valid = 0;
        ref_plot(x, y, c);
        check(next_x == 8'(x + 1), "R2", next_x, 8'(x + 1));
    endtask

    task automatic do_read(int x, int y, string req);
        int g;
        logic [7:0] e;
        wait_idle();
        rd_x = 8'(x); rd_y = 8'(y); rd_valid = 1;
        @(negedge clk);
        rd_valid = 0;
        g = 0;
        while (!rd_done && g < 3000) begin @(negedge clk); g++; end
        e = ref_pixel(x, y);
        check(rd_done, "R11", rd_done, 1);
        check(rd_data == e, req, rd_data, e);
    endtask

    task automatic mem_compare(string req);
        int bad;
        bad = 0;
        foreach (rmem[k]) if (dget(k) !== rmem[k]) bad++;
        foreach (dmem[k]) if (dget(k) !== rget(k)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic set_cfg(int d, int h, int ob, int base, int dz, int ln, int di);
        wait_idle();
        cfg_depth = 4'(d); cfg_height = 2'(h); cfg_obj = ob[0]; cfg_base = 8'(base);
        cfg_draw_zero = dz[0]; cfg_low_nibble = ln[0]; cfg_dither = di[0];
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seen, seed, bx, by, lx, ly;
        int dl [4] = '{2, 4, 8, 6};
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !rd_done && next_x == 0, "R1", {busy, mem_req, rd_done}, 0);
        rst = 0;
        @(negedge clk);
        check(!busy && !mem_req && !rd_done && next_x == 0, "R1", next_x, 0);

        // R3 R4: full row moves to the rear buffer with no traffic
        set_cfg(4, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 8; k++) do_plot(16 + k, 3, k * 17 + 1);
        repeat (6) @(negedge clk);
        check(wr_cnt == 0 && rd_cnt == 0, "R3", wr_cnt + rd_cnt, 0);
        do_plot(40, 3, 5);
        wait_idle();
        check(wr_cnt == 4 && rd_cnt == 0, "R6", wr_cnt * 16 + rd_cnt, 64);
        do_plot(41, 3, 6);
        do_plot(0, 9, 7);
        wait_idle();
        check(wr_cnt == 4 && rd_cnt == 0, "R4", wr_cnt * 16 + rd_cnt, 64);
        do_plot(8, 9, 9);
        check(busy == 1, "R12", busy, 1);
        plot_x = 77; plot_y = 77; plot_color = 8'hFF; plot_valid = 1;
        @(negedge clk);
        plot_valid = 0;
        check(next_x == 9, "R12", next_x, 9);
        wait_idle();
        check(wr_cnt == 8 && rd_cnt == 4, "R6", wr_cnt * 16 + rd_cnt, 132);
        do_read(16, 3, "R11");
        mem_compare("R6");
        check(dget('h700406) == ref_pixel(16, 3) * 0 + dget('h700406) && dget('h700406)[7] == 1'b1, "R5", dget('h700406), 1);
        check(dget('h700416)[7] == 1'b0, "R5", dget('h700416)[7], 0);

        // R2: plot and read in the same cycle
        wait_idle();
        plot_x = 100; plot_y = 20; plot_color = 3; plot_valid = 1;
        rd_x = 100; rd_y = 20; rd_valid = 1;
        @(negedge clk);
        plot_valid = 0; rd_valid = 0;
        ref_plot(100, 20, 3);
        check(next_x == 101, "R2", next_x, 101);
        seen = 0;
        repeat (80) begin @(negedge clk); if (rd_done) seen++; end
        check(seen == 0, "R2", seen, 0);
        do_read(100, 20, "R2");
        mem_compare("R2");

        // R9: transparency tests
        set_cfg(2, 0, 0, 0, 0, 0, 0);
        do_plot(50, 50, 8'h04);
        do_read(50, 50, "R9");
        set_cfg(8, 0, 0, 0, 0, 1, 0);
        do_plot(60, 61, 8'h30);
        do_plot(62, 61, 8'h31);
        do_read(60, 61, "R9");
        do_read(62, 61, "R9");
        check(rd_data == 8'h31, "R9", rd_data, 8'h31);

        // R10: dither nibble select
        set_cfg(4, 0, 0, 0, 1, 0, 1);
        do_plot(1, 0, 8'hA3);
        do_plot(2, 0, 8'hA3);
        do_read(1, 0, "R10");
        check(rd_data == 8'h0A, "R10", rd_data, 8'h0A);
        do_read(2, 0, "R10");
        check(rd_data == 8'h03, "R10", rd_data, 8'h03);

        // R7 R8: fixed address points
        set_cfg(2, 2, 0, 1, 1, 0, 0);
        do_plot(8, 8, 1);
        do_read(8, 8, "R7");
        check(dget('h700590)[7] == 1'b1, "R7", dget('h700590), 8'h80);
        set_cfg(2, 0, 1, 0, 1, 0, 0);
        do_plot(8'h88, 8'h90, 2);
        do_read(8'h88, 8'h90, "R8");
        check(dget('h703211)[7] == 1'b1, "R8", dget('h703211), 8'h80);
        mem_compare("R8");

        // sweep over plane counts, heights and layouts
        seed = 7;
        for (int di = 0; di < 4; di++) begin
            for (int h = 0; h < 4; h++) begin
                for (int ob = 0; ob < 2; ob++) begin
                    set_cfg(dl[di], h, ob, (di + h) & 3, h != 1, h == 2, ob ^ (h & 1));
                    seed = seed * 1103515245 + 12345;
                    bx = (seed >> 16) & 'hF0;
                    by = (seed >> 8) & 'hFF;
                    lx = 0; ly = 0;
                    for (int k = 0; k < 22; k++) begin
                        seed = seed * 1103515245 + 12345;
                        if (k < 12) begin lx = (bx + k) & 'hFF; ly = by; end
                        else begin lx = (seed >> 16) & 'hFF; ly = (seed >> 4) & 'hFF; end
                        do_plot(lx, ly, (seed >> 20) & 'hFF);
                    end
                    do_read((bx + 2) & 'hFF, by, ob ? "R8" : "R7");
                    do_read((bx + 9) & 'hFF, by, "R5");
                    do_read(lx, ly, "R11");
                    mem_compare(ob ? "R8" : "R7");
                end
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule